// File: doc/BRIEF.md
# Lockable CRTC Timing Register Bank

This block holds the byte-wide timing registers of a CRT controller behind a two-location I/O window. Software first writes a register number to the index location and then reads or writes the selected register through the data location. The selected number stays latched, so a run of data accesses all reach the same register.

The first eight registers hold the horizontal timing values, and they can be frozen. Bit 7 of register 0x11 is the freeze control. While that bit is 1, data writes aimed at registers 0x00 to 0x07 are discarded, and reads of those registers still return what they hold. Register 0x11 itself, and every other register, stays writable. Software therefore removes the freeze by rewriting 0x11 with bit 7 clear. Register numbers above the last implemented one read as zero, and writes to them change nothing.

Reads are combinational from the selected location and have no side effects. Turning the stored values into sync and display-enable waveforms is done outside this block.

Top module: `crtc_regbank`

## Requirements
- R1: After reset, the index latch reads 0 and every register 0x00 to 0x18 reads 0, so the freeze is off.
- R2: A write with `io_port_sel`=0 loads `io_wdata` into the index latch. A read with `io_port_sel`=0 returns the latch.
- R3: A write with `io_port_sel`=1 stores `io_wdata` into the register selected by the index, provided that register is implemented (0x00 to 0x18) and not frozen. From the next cycle, a read with `io_port_sel`=1 returns the stored byte.
- R4: Data-port writes leave the index latch unchanged, so consecutive data accesses reach the same register.
- R5: While bit 7 of register 0x11 is 1, data writes to registers 0x00 to 0x07 are dropped, and their reads return the previously stored values.
- R6: While the freeze is on, registers 0x08 to 0x18, including 0x11 itself, accept writes.
- R7: Writing 0x11 with bit 7 clear lifts the freeze, so later writes to 0x00 to 0x07 take effect. Writing it with bit 7 set brings the freeze back.
- R8: With an index of 0x19 or above, the data port reads 0 and writes alter no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_wr | input | 1 | Write strobe, sampled on the rising edge |
| io_port_sel | input | 1 | Location select: 0 = index, 1 = data |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data from the selected location |

## Verification
The bench builds the block with its default parameters: 25 registers, 8 frozen registers, and the freeze bit at bit 7 of register 0x11. At this size, every implemented register and the out-of-range indices up to 0x1F, plus 0xFF, can be swept in full. The sweep is run three times: before the freeze, while it is on, and after it is lifted. Each sweep is followed by a readback of the whole bank, so a write landing on the wrong register or passing the freeze shows up as a mismatch.

// File: rtl/crtc_pkg.sv
package crtc_pkg;
  localparam int unsigned BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;
  // location select values on io_port_sel
  localparam logic SEL_INDEX = 1'b0;
  localparam logic SEL_DATA  = 1'b1;
endpackage

// File: rtl/crtc_index_latch.sv
module crtc_index_latch
  import crtc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load_en,
  input  byte_t load_val,
  output byte_t idx_q
);
  byte_t idx_d;

  always_comb begin
    idx_d = idx_q;
    if (load_en) idx_d = load_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else        idx_q <= idx_d;
  end
endmodule

// File: rtl/crtc_write_gate.sv
module crtc_write_gate
  import crtc_pkg::*;
#(
  parameter int unsigned NUM_REGS   = 25,
  parameter int unsigned PROT_COUNT = 8
) (
  input  logic                data_wr,
  input  byte_t               idx,
  input  logic                lock_on,
  output logic [NUM_REGS-1:0] reg_we
);
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_we
    if (g < PROT_COUNT) begin : g_prot
      assign reg_we[g] = data_wr && (idx == BYTE_W'(g)) && !lock_on;
    end else begin : g_free
      assign reg_we[g] = data_wr && (idx == BYTE_W'(g));
    end
  end
endmodule

// File: rtl/crtc_reg_array.sv
module crtc_reg_array
  import crtc_pkg::*;
#(
  parameter int unsigned NUM_REGS = 25
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NUM_REGS-1:0]            reg_we,
  input  byte_t                          wr_val,
  output logic [NUM_REGS-1:0][BYTE_W-1:0] regs_q
);
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    byte_t nxt;
    always_comb begin
      nxt = regs_q[g];
      if (reg_we[g]) nxt = wr_val;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) regs_q[g] <= '0;
      else        regs_q[g] <= nxt;
    end
  end
endmodule

// File: rtl/crtc_regbank.sv
module crtc_regbank
  import crtc_pkg::*;
#(
  parameter int unsigned NUM_REGS   = 25,
  parameter int unsigned PROT_COUNT = 8,
  parameter int unsigned LOCK_REG   = 17,
  parameter int unsigned LOCK_BIT   = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       io_wr,
  input  logic       io_port_sel,
  input  logic [7:0] io_wdata,
  output logic [7:0] io_rdata
);
  logic                            idx_load;
  logic                            data_wr;
  byte_t                           cur_idx;
  logic                            lock_on;
  logic [NUM_REGS-1:0]             reg_we;
  logic [NUM_REGS-1:0][BYTE_W-1:0] regs_q;
  byte_t                           sel_reg;

  assign idx_load = io_wr && (io_port_sel == SEL_INDEX);
  assign data_wr  = io_wr && (io_port_sel == SEL_DATA);

  crtc_index_latch u_idx (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_en  (idx_load),
    .load_val (io_wdata),
    .idx_q    (cur_idx)
  );

  crtc_write_gate #(.NUM_REGS(NUM_REGS), .PROT_COUNT(PROT_COUNT)) u_gate (
    .data_wr (data_wr),
    .idx     (cur_idx),
    .lock_on (lock_on),
    .reg_we  (reg_we)
  );

  crtc_reg_array #(.NUM_REGS(NUM_REGS)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .reg_we (reg_we),
    .wr_val (io_wdata),
    .regs_q (regs_q)
  );

  assign lock_on = regs_q[LOCK_REG][LOCK_BIT];

  always_comb begin
    sel_reg = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (cur_idx == BYTE_W'(i)) sel_reg = regs_q[i];
    end
  end

  assign io_rdata = (io_port_sel == SEL_DATA) ? sel_reg : cur_idx;
endmodule

// File: rtl/crtc_regbank_chk.sv
module crtc_regbank_chk #(
  parameter int unsigned NUM_REGS   = 25,
  parameter int unsigned PROT_COUNT = 8
) (
  input logic       clk,
  input logic       rst_n,
  input logic       io_wr,
  input logic       io_port_sel,
  input logic [7:0] io_wdata,
  input logic [7:0] io_rdata,
  input logic [7:0] cur_idx,
  input logic       lock_on
);
  // R2
  idx_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && !io_port_sel) |=> (cur_idx == $past(io_wdata)));

  // R4
  idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_port_sel) |=> $stable(cur_idx));

  // R3
  data_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_port_sel && (cur_idx < 8'(NUM_REGS)) &&
     !(lock_on && (cur_idx < 8'(PROT_COUNT))))
    |=> (!io_port_sel || (io_rdata == $past(io_wdata))));

  // R5
  frozen_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_port_sel && lock_on && (cur_idx < 8'(PROT_COUNT)))
    |=> (!io_port_sel || (io_rdata == $past(io_rdata))));

  // R8
  out_of_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_port_sel && (cur_idx >= 8'(NUM_REGS))) |-> (io_rdata == 8'h00));
endmodule

bind crtc_regbank crtc_regbank_chk #(.NUM_REGS(NUM_REGS), .PROT_COUNT(PROT_COUNT)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .io_wr       (io_wr),
  .io_port_sel (io_port_sel),
  .io_wdata    (io_wdata),
  .io_rdata    (io_rdata),
  .cur_idx     (cur_idx),
  .lock_on     (lock_on)
);

// File: tb/crtc_regbank_bench.sv
module crtc_regbank_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       io_wr;
  logic       io_port_sel;
  logic [7:0] io_wdata;
  logic [7:0] io_rdata;

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  logic [7:0] model [0:24];

  always #2.5 clk = ~clk;

  crtc_regbank u_crtc_regbank (
    .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_port_sel(io_port_sel),
    .io_wdata(io_wdata), .io_rdata(io_rdata)
  );

  function automatic bit frozen();
    return model[17][7];
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic bus_write(logic sel, logic [7:0] v);
    @(negedge clk);
    io_wr = 1'b1; io_port_sel = sel; io_wdata = v;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic put(int i, logic [7:0] v);
    bus_write(1'b0, 8'(i));
    bus_write(1'b1, v);
    if (i < 25 && !(frozen() && i < 8)) model[i] = v;
  endtask

  task automatic read_reg(int i, string req);
    bus_write(1'b0, 8'(i));
    io_port_sel = 1'b0; #1;
    check("R2", io_rdata, 8'(i));
    io_port_sel = 1'b1; #1;
    check(req, io_rdata, (i < 25) ? model[i] : 8'h00);
  endtask

  task automatic read_all(string req);
    for (int i = 0; i < 32; i++) read_reg(i, req);
    read_reg(255, "R8");
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    io_wr = 0; io_port_sel = 0; io_wdata = 0; rst_n = 0;
    for (int i = 0; i < 25; i++) model[i] = 8'h00;
    #12 rst_n = 1;
    // R1: reset state
    @(negedge clk); #1;
    check("R1", io_rdata, 8'h00);
    read_all("R1");
    // R3/R8: unfrozen sweep, out-of-range writes must not alias
    for (int i = 0; i < 32; i++) begin
      logic [7:0] v = 8'(i * 7 + 3);
      if (i == 17) v[7] = 1'b0;
      put(i, v);
    end
    put(255, 8'hA5);
    read_all("R3");
    // R4: index held across data writes
    bus_write(1'b0, 8'h09);
    bus_write(1'b1, 8'h11);
    bus_write(1'b1, 8'h22);
    model[9] = 8'h22;
    io_port_sel = 1'b0; #1;
    check("R4", io_rdata, 8'h09);
    io_port_sel = 1'b1; #1;
    check("R4", io_rdata, 8'h22);
    // R5/R6: freeze on, sweep again
    put(17, 8'h8C);
    for (int i = 0; i < 25; i++) begin
      logic [7:0] v = ~8'(i * 5 + 1);
      if (i == 17) v[7] = 1'b1;
      put(i, v);
    end
    for (int i = 0; i < 8; i++) read_reg(i, "R5");
    for (int i = 8; i < 25; i++) read_reg(i, "R6");
    // R7: lift freeze, frozen range writable again
    put(17, 8'h3C);
    for (int i = 0; i < 8; i++) put(i, 8'(8'hC0 + i));
    for (int i = 0; i < 8; i++) read_reg(i, "R7");
    // R7: freeze back on
    put(17, 8'hBC);
    put(3, 8'h55);
    read_reg(3, "R7");
    read_all("R7");
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule